// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the byte-level engine of a two-wire bus slave that fronts a 512-byte memory and a single 8-bit configuration register. A bit-level front end decodes the bus and passes in one-cycle events: a start, a stop, a completed received byte, or the master's acknowledge or no-acknowledge after a byte the slave sent. It also passes a level that shows whether a byte is partly clocked in. The controller answers each received byte with an acknowledge decision. For reads, it hands the front end the next byte to shift out.

Writes collect in a page buffer. They are committed to the array when a stop arrives at a legal point, and the slave then stays busy for a programmable number of clocks. While busy it refuses every slave address byte, so the master can poll for completion. A single address counter serves both writes and reads. Writes wrap the counter inside a 16-byte page, and reads wrap it across the whole 512-byte space.

Top module: `ee2w_slave`

## Requirements
- R1: The slave address byte is acknowledged when bits 7:5 are 101 and bits 3:2 are 00. Bit 4 picks the target (0 = array, 1 = configuration register), bit 1 is address bit 8, and bit 0 picks the direction (1 = read). Every answer is an `ack_stb` pulse in the cycle after `ev_byte`, with `ack_ok` = 1 for acknowledge.
- R2: A slave address byte that does not match gets `ack_ok` = 0. Every byte that follows is ignored, with no `ack_stb` and no `tx_stb`, until the next start.
- R3: In an array write, the byte after the slave address forms address bits 7:0, and every data byte is acknowledged. Successive bytes go to incrementing addresses whose low 4 bits wrap inside the 16-byte page. A later byte overwrites an earlier byte at the same location. After the stop, the counter points one past the last location written.
- R4: A write ends with a commit only on a stop that comes after at least one full data byte while `mid_byte` is 0. A stop in any other position, or a start, leaves memory and the configuration register unchanged and starts no busy period.
- R5: A commit holds `busy` high from the stop cycle for `WR_CYCLES` clocks. While busy, every slave address byte gets `ack_ok` = 0.
- R6: A slave address byte and an address byte followed directly by a stop only load the counter.
- R7: An array read that does not follow an address byte returns the byte at the counter. The counter then advances by one.
- R8: A read continues with the next byte, one cycle after each master acknowledge, and wraps from 1FFh to 000h. A master no-acknowledge ends the read, and no further byte is sent.
- R9: An array write with a slave address byte and an address byte, followed by a repeated start and a read slave address byte, returns data from that address.
- R10: A configuration write takes an address byte (ignored, counter unchanged) and then exactly one data byte. A second data byte gets `ack_ok` = 0 and cancels the write. A committed configuration write also starts the busy period. A configuration read returns exactly one byte, and after the master's reply the slave ignores the bus until the next start.
- R11: After reset `busy`, `ack_stb` and `tx_stb` are 0 and the counter is 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen (one cycle) |
| ev_stop | input | 1 | Stop seen (one cycle) |
| ev_byte | input | 1 | A full byte was received (one cycle) |
| rx_byte | input | 8 | Received byte, valid with `ev_byte` |
| ev_mack | input | 1 | Master acknowledged a transmitted byte |
| ev_mnack | input | 1 | Master did not acknowledge a transmitted byte |
| mid_byte | input | 1 | Some bits of the current byte have been clocked in |
| ack_stb | output | 1 | Acknowledge decision valid (one cycle) |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_stb | output | 1 | Byte to transmit valid (one cycle) |
| tx_data | output | 8 | Byte to transmit |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
Some checks run on every cycle. A slave address byte that arrives while busy is always refused. The counter's page bits never move during a page write, and each master acknowledge during an array read steps the counter by exactly one. Busy can only rise on a clean stop. An idle slave never responds, and a configuration read never sends a second byte. Only the scenarios can show data correctness. That covers in-page wrap and overwrite, the full-space read wrap, aborted writes leaving memory intact, the counter-only load and the one-byte configuration access. A behavioural model in the bench predicts every output on every clock for these.

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_mack,
  input  logic       ev_mnack,
  input  logic       mid_byte,
  output logic       ack_stb,
  output logic       ack_ok,
  output logic       tx_stb,
  output logic [7:0] tx_data,
  output logic       busy
);
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int CW     = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_READ} st_t;

  st_t               state;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pmask;
  logic [ADDR_W-1:0] cnt;
  logic              sel_ctrl, a8, got_data;
  logic [7:0]        creg, cpend;
  logic [CW-1:0]     bcnt;

  wire plain   = !ev_start && !ev_stop;
  wire dev_ok  = rx_byte[7:5] == 3'b101 && rx_byte[3:2] == 2'b00;
  wire commit  = ev_stop && !ev_start && state == S_WDATA && got_data && !mid_byte;
  wire pb_we   = plain && ev_byte && state == S_WDATA && !sel_ctrl;
  wire [PAGE_W-1:0] low = cnt[PAGE_W-1:0];

  assign busy = bcnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ack_stb  <= 1'b0;
      ack_ok   <= 1'b0;
      tx_stb   <= 1'b0;
      tx_data  <= '0;
      cnt      <= '0;
      bcnt     <= '0;
      creg     <= '0;
      cpend    <= '0;
      pmask    <= '0;
      got_data <= 1'b0;
      sel_ctrl <= 1'b0;
      a8       <= 1'b0;
    end else begin
      ack_stb <= 1'b0;
      tx_stb  <= 1'b0;
      if (commit) bcnt <= CW'(WR_CYCLES);
      else if (busy) bcnt <= bcnt - 1'b1;

      if (ev_start) begin
        state    <= S_DEV;
        pmask    <= '0;
        got_data <= 1'b0;
      end else if (ev_stop) begin
        if (commit && sel_ctrl) creg <= cpend;
        state    <= S_IDLE;
        pmask    <= '0;
        got_data <= 1'b0;
      end else begin
        case (state)
          S_DEV: if (ev_byte) begin
            ack_stb <= 1'b1;
            if (!busy && dev_ok) begin
              ack_ok   <= 1'b1;
              sel_ctrl <= rx_byte[4];
              a8       <= rx_byte[1];
              if (rx_byte[0]) begin
                state  <= S_READ;
                tx_stb <= 1'b1;
                if (rx_byte[4]) tx_data <= creg;
                else begin
                  tx_data <= mem[cnt];
                  cnt     <= cnt + 1'b1;
                end
              end else state <= S_WADDR;
            end else begin
              ack_ok <= 1'b0;
              state  <= S_IDLE;
            end
          end
          S_WADDR: if (ev_byte) begin
            ack_stb <= 1'b1;
            ack_ok  <= 1'b1;
            if (!sel_ctrl) cnt <= {a8, rx_byte};
            state <= S_WDATA;
          end
          S_WDATA: if (ev_byte) begin
            ack_stb <= 1'b1;
            if (sel_ctrl) begin
              if (got_data) begin
                ack_ok   <= 1'b0;
                got_data <= 1'b0;
                state    <= S_IDLE;
              end else begin
                ack_ok   <= 1'b1;
                cpend    <= rx_byte;
                got_data <= 1'b1;
              end
            end else begin
              ack_ok                <= 1'b1;
              pmask[low]            <= 1'b1;
              cnt[PAGE_W-1:0]       <= low + 1'b1;
              got_data              <= 1'b1;
            end
          end
          S_READ:
            if (ev_mack) begin
              if (sel_ctrl) state <= S_IDLE;
              else begin
                tx_stb  <= 1'b1;
                tx_data <= mem[cnt];
                cnt     <= cnt + 1'b1;
              end
            end else if (ev_mnack) state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[low] <= rx_byte;
    if (commit && !sel_ctrl)
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{cnt[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    plain && ev_byte && state == S_DEV && busy |=> ack_stb && !ack_ok);

  p_page_stay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |=> cnt[ADDR_W-1:PAGE_W] == $past(cnt[ADDR_W-1:PAGE_W]));

  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    plain && state == S_READ && ev_mack && !sel_ctrl |=> cnt == ADDR_W'($past(cnt) + 1'b1));

  p_clean_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop && !mid_byte));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !ev_start |=> !ack_stb && !tx_stb);

  p_ctrl_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    plain && state == S_READ && sel_ctrl && ev_mack |=> !tx_stb && state == S_IDLE);
endmodule

// File: tb/ee2w_slave_test.sv
module ee2w_slave_test;
  localparam int W = 40;
  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_mack = 0, ev_mnack = 0, mid_byte = 0;
  logic [7:0] rx_byte = 0;
  logic ack_stb, ack_ok, tx_stb, busy;
  logic [7:0] tx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ee2w_slave #(.PAGE_W(4), .WR_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte),
    .rx_byte(rx_byte), .ev_mack(ev_mack), .ev_mnack(ev_mnack), .mid_byte(mid_byte),
    .ack_stb(ack_stb), .ack_ok(ack_ok), .tx_stb(tx_stb), .tx_data(tx_data), .busy(busy));

  // reference model: 0 idle, 1 expect slave byte, 2 expect address, 3 data in, 4 sending
  int ms = 0, mcnt = 0, mbl = 0, mcreg = 0, mcp = 0, msel = 0, ma8 = 0;
  bit mgot = 0;
  int mmem [512];
  int qa [$];
  int qd [$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit st, sp, bv, input logic [7:0] b, input bit ma, mn, mid,
                      input string tag);
    bit e_ack = 0, e_ok = 0, e_tx = 0, commit;
    int e_d = 0;
    ev_start = st; ev_stop = sp; ev_byte = bv; rx_byte = b;
    ev_mack = ma; ev_mnack = mn; mid_byte = mid;
    commit = sp && !st && ms == 3 && mgot && !mid;
    if (st) begin ms = 1; qa.delete(); qd.delete(); mgot = 0; end
    else if (sp) begin
      if (commit) begin
        if (msel) mcreg = mcp;
        else foreach (qa[k]) mmem[qa[k]] = qd[k];
      end
      ms = 0; qa.delete(); qd.delete(); mgot = 0;
    end else if (ms == 1 && bv) begin
      e_ack = 1;
      if (mbl == 0 && b[7:5] == 3'b101 && b[3:2] == 2'b00) begin
        e_ok = 1; msel = b[4]; ma8 = b[1];
        if (b[0]) begin
          ms = 4; e_tx = 1;
          if (msel) e_d = mcreg;
          else begin e_d = mmem[mcnt]; mcnt = (mcnt + 1) % 512; end
        end else ms = 2;
      end else ms = 0;
    end else if (ms == 2 && bv) begin
      e_ack = 1; e_ok = 1;
      if (!msel) mcnt = ma8 * 256 + b;
      ms = 3;
    end else if (ms == 3 && bv) begin
      e_ack = 1;
      if (msel) begin
        if (mgot) begin e_ok = 0; ms = 0; mgot = 0; end
        else begin e_ok = 1; mcp = b; mgot = 1; end
      end else begin
        e_ok = 1; qa.push_back(mcnt); qd.push_back(b); mgot = 1;
        mcnt = (mcnt / 16) * 16 + (mcnt + 1) % 16;
      end
    end else if (ms == 4) begin
      if (ma) begin
        if (msel) ms = 0;
        else begin e_tx = 1; e_d = mmem[mcnt]; mcnt = (mcnt + 1) % 512; end
      end else if (mn) ms = 0;
    end
    if (commit) mbl = W; else if (mbl > 0) mbl--;
    @(posedge clk); #1;
    chk(ack_stb == e_ack, tag, "ack_stb", ack_stb, e_ack);
    if (e_ack) chk(ack_ok == e_ok, tag, "ack_ok", ack_ok, e_ok);
    chk(tx_stb == e_tx, tag, "tx_stb", tx_stb, e_tx);
    if (e_tx) chk(tx_data == e_d[7:0], tag, "tx_data", tx_data, e_d);
    chk(busy == (mbl != 0), tag, "busy", busy, mbl != 0);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic st_(input string tag); step(1, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic sp_(input bit mid, input string tag); step(0, 1, 0, 0, 0, 0, mid, tag); endtask
  task automatic by_(input logic [7:0] b, input string tag); step(0, 0, 1, b, 0, 0, 0, tag); endtask
  task automatic ma_(input string tag); step(0, 0, 0, 0, 1, 0, 0, tag); endtask
  task automatic mn_(input string tag); step(0, 0, 0, 0, 0, 1, 0, tag); endtask

  initial begin
    for (int i = 0; i < 512; i++) mmem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk(busy == 0 && ack_stb == 0 && tx_stb == 0, "R11", "reset outputs", busy, 0);
    idle(2, "R11");
    // R2 mismatched slave byte then ignored bytes
    st_("R2"); by_(8'hA4, "R2"); by_(8'hA0, "R2"); by_(8'h10, "R2"); sp_(0, "R2");
    // R1 R3 page write: 12 bytes from 0x01A, wrap inside page
    st_("R1"); by_(8'hA0, "R1"); by_(8'h1A, "R3");
    for (int i = 0; i < 12; i++) by_(8'h30 + 8'(i), "R3");
    sp_(0, "R3");
    // R5 polling while busy
    st_("R5"); by_(8'hA1, "R5"); sp_(0, "R5");
    idle(W, "R5");
    // R7 current address read at counter (0x016) then R8 step within
    st_("R7"); by_(8'hA1, "R7"); ma_("R8"); mn_("R8"); sp_(0, "R8");
    // R3 overwrite: 18 bytes at 0x120
    st_("R3"); by_(8'hA2, "R3"); by_(8'h20, "R3");
    for (int i = 0; i < 18; i++) by_(8'h80 + 8'(i), "R3");
    sp_(0, "R3"); idle(W, "R3");
    st_("R3"); by_(8'hA2, "R3"); by_(8'h20, "R3"); st_("R9"); by_(8'hA1, "R9");
    for (int i = 0; i < 16; i++) ma_("R3");
    mn_("R8"); sp_(0, "R8");
    // R4 aborts: stop mid byte, start after data, stop after address (R6)
    st_("R4"); by_(8'hA0, "R4"); by_(8'h50, "R4"); by_(8'h77, "R4"); sp_(1, "R4");
    st_("R4"); by_(8'hA0, "R4"); by_(8'h18, "R4"); by_(8'h66, "R4"); st_("R4"); sp_(0, "R4");
    st_("R6"); by_(8'hA0, "R6"); by_(8'h18, "R6"); sp_(0, "R6");
    st_("R6"); by_(8'hA1, "R6"); ma_("R4"); mn_("R4"); sp_(0, "R4");
    // R8 R9 wrap 0x1FF -> 0x000
    st_("R8"); by_(8'hA2, "R8"); by_(8'hFE, "R8"); by_(8'hE1, "R8"); by_(8'hE2, "R8");
    sp_(0, "R8"); idle(W, "R8");
    st_("R8"); by_(8'hA0, "R8"); by_(8'h00, "R8"); by_(8'hD0, "R8"); sp_(0, "R8"); idle(W, "R8");
    st_("R9"); by_(8'hA2, "R9"); by_(8'hFE, "R9"); st_("R9"); by_(8'hA1, "R9");
    ma_("R8"); ma_("R8"); mn_("R8"); ma_("R8"); sp_(0, "R8");
    // R10 configuration register
    st_("R10"); by_(8'hB0, "R10"); by_(8'hFF, "R10"); by_(8'h5C, "R10"); sp_(0, "R10");
    idle(W, "R10");
    st_("R10"); by_(8'hB1, "R10"); ma_("R10"); ma_("R10"); sp_(0, "R10");
    st_("R10"); by_(8'hB0, "R10"); by_(8'hFF, "R10"); by_(8'h11, "R10"); by_(8'h22, "R10");
    sp_(0, "R10"); idle(3, "R10");
    st_("R10"); by_(8'hB1, "R10"); mn_("R10"); sp_(0, "R10");
    // R7 counter untouched by configuration access
    st_("R7"); by_(8'hA1, "R7"); mn_("R7"); sp_(0, "R7");
    idle(2, "R11");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule